// File: doc/BRIEF.md
# Speculative Memory Operand Renaming Predictor

This block sits in the front end of an out-of-order core and guesses, before any address is generated, whether a load reads the location that an earlier in-flight store or read-modify-write wrote. It makes that guess by comparing address expressions as register names: base register, optional index register with scale, and displacement. It does not compare computed addresses. When the guess is a hit, the block hands back the producer's physical tag, so the consumer can read its value directly from that register. The guess costs no latency waiting on address generation.

Every cycle the block takes one decoded memory micro-op together with any register-write or stack-adjust events from the same cycle. The events count as older than the op. An eight-entry table, filled round-robin, holds the address expressions of recent producers. Entries based on the stack pointer follow push, pop, call and return: each such step subtracts the stack delta from the stored displacement. Any other register write invalidates every entry that uses the written register. A verification port later reports whether the load truly aliased. When that report disagrees with the prediction, the block raises a flush request and empties the table.

Top module: `mop_rename_top`

## Requirements
- R1: Only general-purpose operands (op_gpr=1) of 32 or 64 bits are tracked; op_size encodes 0=8, 1=16, 2=32, 3=64 bits. Any other operand never allocates an entry and never receives a bypass.
- R2: An operand without a base register (op_base_vld=0, the absolute or instruction-pointer-relative forms) is never tracked and never bypassed.
- R3: op_kind encodes 0=load, 1=store, 2=read-modify-write, 3=no memory op. A load or read-modify-write whose expression matches a valid entry raises byp_vld, with byp_tag equal to that entry's producer tag, one cycle after the op. A match needs equal base, equal index presence, equal index and scale when an index is present, equal displacement and equal size.
- R4: A store, then a read-modify-write, then a load, all with one expression, chain: the read-modify-write gets the store's tag, and the load gets the read-modify-write's tag.
- R5: When several entries match, the most recently allocated one supplies the tag.
- R6: A stack adjust (sp_vld, signed sp_delta, stack pointer register id 4) subtracts sp_delta from the displacement of each entry whose base is the stack pointer. It invalidates each entry that uses the stack pointer as its index.
- R7: A register write (rw_vld, rw_reg) invalidates every entry that uses that register as base or index, and this includes the stack pointer.
- R8: An access whose base is another register holding a copy of the stack pointer never matches an entry based on the stack pointer.
- R9: The table holds 8 entries, filled round-robin from entry 0 after reset or flush. The ninth allocation overwrites the oldest entry.
- R10: A verify report (vfy_vld) whose predicted-hit flag differs from its alias result raises flush_req, with flush_tag equal to vfy_ltag, one cycle later, and empties the table. A report that agrees raises no flush.
- R11: Register-write and stack-adjust events in a cycle apply before that cycle's op is looked up and allocated. A mispredict in a cycle cancels that cycle's allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_vld | input | 1 | Micro-op present this cycle |
| op_kind | input | 2 | 0 load, 1 store, 2 read-modify-write, 3 none |
| op_size | input | 2 | Operand size code (0=8 .. 3=64 bits) |
| op_gpr | input | 1 | Operand targets a general-purpose register |
| op_base_vld | input | 1 | Address has a base register |
| op_base | input | 4 | Base register id |
| op_idx_vld | input | 1 | Address has an index register |
| op_idx | input | 4 | Index register id |
| op_scale | input | 2 | Index scale code |
| op_disp | input | 32 | Displacement |
| op_ptag | input | 7 | Producer physical tag of a store or read-modify-write |
| rw_vld | input | 1 | Architectural register write this cycle |
| rw_reg | input | 4 | Register written |
| sp_vld | input | 1 | Push, pop, call or return stack adjust |
| sp_delta | input | 32 | Signed stack-pointer change |
| vfy_vld | input | 1 | Address verification result present |
| vfy_pred_hit | input | 1 | Whether the load was predicted to hit |
| vfy_alias | input | 1 | Whether the addresses truly matched |
| vfy_ltag | input | 7 | Tag of the verified load |
| byp_vld | output | 1 | Bypass predicted for the previous op |
| byp_tag | output | 7 | Producer tag to read from |
| flush_req | output | 1 | Recovery request after a mispredict |
| flush_tag | output | 7 | Load tag behind the recovery request |

## Verification
The hardest states to reach from the ports are those where a table entry has been changed by an event, not by the op that allocated it. Examples are a displacement that has drifted through a push and then a pop, an entry invalidated by a stack-pointer write while a frame-pointer copy stays live, and eviction on wrap-around while an older duplicate remains. Directed sequences build each of these, with the register event issued in the same cycle as an op where the ordering matters. A random phase then follows, with base registers, displacements and stack deltas drawn from small sets. The small sets make hits, repeated hits, drift and invalidation frequent, and every output is compared with a bench model of the table.

// File: rtl/mop_pkg.sv
package mop_pkg;
    localparam int REG_W  = 4;
    localparam int TAG_W  = 7;
    localparam int DISP_W = 32;
    localparam int DEPTH  = 8;
    localparam int PTR_W  = $clog2(DEPTH);
    localparam logic [REG_W-1:0] SP_ID = 4'd4;

    typedef enum logic [1:0] {
        K_LOAD  = 2'd0,
        K_STORE = 2'd1,
        K_RMW   = 2'd2,
        K_NONE  = 2'd3
    } mop_kind_e;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } mop_size_e;

    typedef struct packed {
        logic [REG_W-1:0]  base;
        logic              idx_vld;
        logic [REG_W-1:0]  idx;
        logic [1:0]        scale;
        logic [DISP_W-1:0] disp;
        mop_size_e         size;
    } addr_sig_t;

    typedef struct packed {
        logic              valid;
        addr_sig_t         sig;
        logic [TAG_W-1:0]  ptag;
    } ent_t;

    function automatic logic sig_eq(addr_sig_t a, addr_sig_t b);
        logic idx_ok;
        idx_ok = (a.idx_vld == b.idx_vld) &&
                 (!a.idx_vld || (a.idx == b.idx && a.scale == b.scale));
        return idx_ok && (a.base == b.base) && (a.disp == b.disp) && (a.size == b.size);
    endfunction

    function automatic logic op_eligible(logic gpr, mop_size_e size, logic base_vld);
        return gpr && base_vld && (size == SZ_32 || size == SZ_64);
    endfunction
endpackage

// File: rtl/mop_entry.sv
module mop_entry
    import mop_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear_i,
    input  logic                 wr_en_i,
    input  ent_t                 wr_ent_i,
    input  logic                 rw_vld_i,
    input  logic [REG_W-1:0]     rw_reg_i,
    input  logic                 sp_vld_i,
    input  logic [DISP_W-1:0]    sp_delta_i,
    input  addr_sig_t            key_i,
    output logic                 hit_o,
    output logic [TAG_W-1:0]     ptag_o
);
    ent_t ent_q;
    ent_t post;

    // Events of this cycle are older than the op, so they shape the state
    // that the lookup sees and that is kept if no allocation lands here.
    always_comb begin
        post = ent_q;
        if (sp_vld_i) begin
            if (ent_q.sig.idx_vld && ent_q.sig.idx == SP_ID) begin
                post.valid = 1'b0;
            end else if (ent_q.sig.base == SP_ID) begin
                post.sig.disp = ent_q.sig.disp - sp_delta_i;
            end
        end
        if (rw_vld_i && (ent_q.sig.base == rw_reg_i ||
                         (ent_q.sig.idx_vld && ent_q.sig.idx == rw_reg_i))) begin
            post.valid = 1'b0;
        end
    end

    assign hit_o  = post.valid && sig_eq(post.sig, key_i);
    assign ptag_o = ent_q.ptag;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            ent_q <= '0;
        end else if (wr_en_i) begin
            ent_q <= wr_ent_i;
        end else begin
            ent_q <= post;
        end
    end
endmodule

// File: rtl/mop_young_sel.sv
module mop_young_sel
    import mop_pkg::*;
(
    input  logic [DEPTH-1:0] hit_i,
    input  logic [PTR_W-1:0] wp_i,
    output logic             found_o,
    output logic [PTR_W-1:0] sel_o
);
    logic [PTR_W-1:0] cand;

    // The slot just behind the write pointer is the youngest; walk backwards.
    always_comb begin
        found_o = 1'b0;
        sel_o   = '0;
        cand    = '0;
        for (int k = 1; k <= DEPTH; k++) begin
            cand = wp_i - PTR_W'(k);
            if (!found_o && hit_i[cand]) begin
                found_o = 1'b1;
                sel_o   = cand;
            end
        end
    end
endmodule

// File: rtl/mop_verify.sv
module mop_verify
    import mop_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             vfy_vld_i,
    input  logic             pred_hit_i,
    input  logic             alias_i,
    input  logic [TAG_W-1:0] ltag_i,
    output logic             mispredict_o,
    output logic             flush_req_o,
    output logic [TAG_W-1:0] flush_tag_o
);
    assign mispredict_o = vfy_vld_i && (pred_hit_i != alias_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            flush_req_o <= 1'b0;
            flush_tag_o <= '0;
        end else begin
            flush_req_o <= mispredict_o;
            flush_tag_o <= ltag_i;
        end
    end
endmodule

// File: rtl/mop_rename_top.sv
module mop_rename_top
    import mop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_vld,
    input  logic [1:0]        op_kind,
    input  logic [1:0]        op_size,
    input  logic              op_gpr,
    input  logic              op_base_vld,
    input  logic [REG_W-1:0]  op_base,
    input  logic              op_idx_vld,
    input  logic [REG_W-1:0]  op_idx,
    input  logic [1:0]        op_scale,
    input  logic [DISP_W-1:0] op_disp,
    input  logic [TAG_W-1:0]  op_ptag,
    input  logic              rw_vld,
    input  logic [REG_W-1:0]  rw_reg,
    input  logic              sp_vld,
    input  logic [DISP_W-1:0] sp_delta,
    input  logic              vfy_vld,
    input  logic              vfy_pred_hit,
    input  logic              vfy_alias,
    input  logic [TAG_W-1:0]  vfy_ltag,
    output logic              byp_vld,
    output logic [TAG_W-1:0]  byp_tag,
    output logic              flush_req,
    output logic [TAG_W-1:0]  flush_tag
);
    mop_kind_e        kind;
    addr_sig_t        key;
    ent_t             wr_ent;
    logic             elig, lookup_en, alloc_en, mispredict, found;
    logic [DEPTH-1:0] hit_vec;
    logic [TAG_W-1:0] ptag_arr [DEPTH];
    logic [PTR_W-1:0] wp_q, sel;

    assign kind = mop_kind_e'(op_kind);

    always_comb begin
        key.base    = op_base;
        key.idx_vld = op_idx_vld;
        key.idx     = op_idx;
        key.scale   = op_scale;
        key.disp    = op_disp;
        key.size    = mop_size_e'(op_size);
        wr_ent.valid = 1'b1;
        wr_ent.sig   = key;
        wr_ent.ptag  = op_ptag;
    end

    assign elig      = op_vld && op_eligible(op_gpr, mop_size_e'(op_size), op_base_vld);
    assign lookup_en = elig && (kind == K_LOAD || kind == K_RMW);
    assign alloc_en  = elig && (kind == K_STORE || kind == K_RMW) && !mispredict;

    mop_verify u_vfy (
        .clk          (clk),
        .rst          (rst),
        .vfy_vld_i    (vfy_vld),
        .pred_hit_i   (vfy_pred_hit),
        .alias_i      (vfy_alias),
        .ltag_i       (vfy_ltag),
        .mispredict_o (mispredict),
        .flush_req_o  (flush_req),
        .flush_tag_o  (flush_tag)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        mop_entry u_ent (
            .clk        (clk),
            .rst        (rst),
            .clear_i    (mispredict),
            .wr_en_i    (alloc_en && (wp_q == PTR_W'(g))),
            .wr_ent_i   (wr_ent),
            .rw_vld_i   (rw_vld),
            .rw_reg_i   (rw_reg),
            .sp_vld_i   (sp_vld),
            .sp_delta_i (sp_delta),
            .key_i      (key),
            .hit_o      (hit_vec[g]),
            .ptag_o     (ptag_arr[g])
        );
    end

    mop_young_sel u_sel (
        .hit_i   (hit_vec),
        .wp_i    (wp_q),
        .found_o (found),
        .sel_o   (sel)
    );

    always_ff @(posedge clk) begin
        if (rst || mispredict) begin
            wp_q <= '0;
        end else if (alloc_en) begin
            wp_q <= wp_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            byp_vld <= 1'b0;
            byp_tag <= '0;
        end else begin
            byp_vld <= lookup_en && found;
            byp_tag <= ptag_arr[sel];
        end
    end
endmodule

// File: rtl/mop_rename_chk.sv
module mop_rename_chk
    import mop_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              op_vld,
    input logic [1:0]        op_kind,
    input logic [1:0]        op_size,
    input logic              op_gpr,
    input logic              op_base_vld,
    input logic              vfy_vld,
    input logic              vfy_pred_hit,
    input logic              vfy_alias,
    input logic [TAG_W-1:0]  vfy_ltag,
    input logic              byp_vld,
    input logic              flush_req,
    input logic [TAG_W-1:0]  flush_tag
);
    logic mis;
    assign mis = vfy_vld && (vfy_pred_hit != vfy_alias);

    // R10
    flush_raise_chk: assert property (@(posedge clk) disable iff (rst)
        mis |=> (flush_req && flush_tag == $past(vfy_ltag)));

    // R10
    flush_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !mis |=> !flush_req);

    // R10
    table_empty_chk: assert property (@(posedge clk) disable iff (rst)
        mis |-> ##2 !byp_vld);

    // R1
    size_class_chk: assert property (@(posedge clk) disable iff (rst)
        (op_vld && (!op_gpr || op_size < 2'd2)) |=> !byp_vld);

    // R2
    base_needed_chk: assert property (@(posedge clk) disable iff (rst)
        (op_vld && !op_base_vld) |=> !byp_vld);

    // R3
    consumer_only_chk: assert property (@(posedge clk) disable iff (rst)
        !(op_vld && (op_kind == 2'd0 || op_kind == 2'd2)) |=> !byp_vld);
endmodule

bind mop_rename_top mop_rename_chk chk_i (.*);

// File: tb/mop_rename_top_tb_top.sv
`timescale 1ns/1ps
module mop_rename_top_tb_top;
    import mop_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              op_vld, op_gpr, op_base_vld, op_idx_vld;
    logic [1:0]        op_kind, op_size, op_scale;
    logic [REG_W-1:0]  op_base, op_idx, rw_reg;
    logic [DISP_W-1:0] op_disp, sp_delta;
    logic [TAG_W-1:0]  op_ptag, vfy_ltag;
    logic              rw_vld, sp_vld, vfy_vld, vfy_pred_hit, vfy_alias;
    logic              byp_vld, flush_req;
    logic [TAG_W-1:0]  byp_tag, flush_tag;

    int checks = 0;
    int errors = 0;

    // bench model of the table
    logic              m_v    [DEPTH];
    logic [REG_W-1:0]  m_base [DEPTH];
    logic              m_iv   [DEPTH];
    logic [REG_W-1:0]  m_idx  [DEPTH];
    logic [1:0]        m_sc   [DEPTH];
    logic [DISP_W-1:0] m_disp [DEPTH];
    logic [1:0]        m_sz   [DEPTH];
    logic [TAG_W-1:0]  m_tag  [DEPTH];
    int                m_wp;

    always #2 clk = ~clk;

    mop_rename_top dut_i (.*);

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic idle();
        op_vld = 0; op_kind = 2'd3; op_size = 2'd2; op_gpr = 1; op_base_vld = 1;
        op_base = '0; op_idx_vld = 0; op_idx = '0; op_scale = 2'd0; op_disp = '0; op_ptag = '0;
        rw_vld = 0; rw_reg = '0; sp_vld = 0; sp_delta = '0;
        vfy_vld = 0; vfy_pred_hit = 0; vfy_alias = 0; vfy_ltag = '0;
    endtask

    task automatic model_clear();
        for (int i = 0; i < DEPTH; i++) m_v[i] = 0;
        m_wp = 0;
    endtask

    task automatic model_step(output logic ebv, output logic [TAG_W-1:0] ebt,
                              output logic efr, output logic [TAG_W-1:0] eft);
        logic mis, elig, found;
        int sel;
        mis = vfy_vld && (vfy_pred_hit != vfy_alias);
        for (int i = 0; i < DEPTH; i++) begin
            if (sp_vld) begin
                if (m_iv[i] && m_idx[i] == SP_ID) m_v[i] = 0;
                else if (m_base[i] == SP_ID) m_disp[i] = m_disp[i] - sp_delta;
            end
            if (rw_vld && (m_base[i] == rw_reg || (m_iv[i] && m_idx[i] == rw_reg))) m_v[i] = 0;
        end
        elig = op_vld && op_gpr && op_base_vld && op_size >= 2'd2;
        found = 0; sel = 0;
        for (int k = 1; k <= DEPTH; k++) begin
            int i;
            i = (m_wp - k + DEPTH) % DEPTH;
            if (!found && m_v[i] && m_base[i] == op_base && m_iv[i] == op_idx_vld &&
                (!op_idx_vld || (m_idx[i] == op_idx && m_sc[i] == op_scale)) &&
                m_disp[i] == op_disp && m_sz[i] == op_size) begin
                found = 1; sel = i;
            end
        end
        ebv = elig && (op_kind == 2'd0 || op_kind == 2'd2) && found;
        ebt = m_tag[sel];
        if (mis) begin
            model_clear();
        end else if (elig && (op_kind == 2'd1 || op_kind == 2'd2)) begin
            m_v[m_wp] = 1; m_base[m_wp] = op_base; m_iv[m_wp] = op_idx_vld;
            m_idx[m_wp] = op_idx; m_sc[m_wp] = op_scale; m_disp[m_wp] = op_disp;
            m_sz[m_wp] = op_size; m_tag[m_wp] = op_ptag;
            m_wp = (m_wp + 1) % DEPTH;
        end
        efr = mis; eft = vfy_ltag;
    endtask

    task automatic tick(string req);
        logic ebv, efr;
        logic [TAG_W-1:0] ebt, eft;
        model_step(ebv, ebt, efr, eft);
        @(negedge clk);
        checks++;
        if (byp_vld !== ebv || (ebv && byp_tag !== ebt) ||
            flush_req !== efr || (efr && flush_tag !== eft)) begin
            errors++;
            $display("FAIL %s: byp=%0b/%0d flush=%0b/%0d expected byp=%0b/%0d flush=%0b/%0d",
                     req, byp_vld, byp_tag, flush_req, flush_tag, ebv, ebt, efr, eft);
        end
        idle();
    endtask

    task automatic expect_byp(string req, logic v, logic [TAG_W-1:0] t);
        checks++;
        if (byp_vld !== v || (v && byp_tag !== t)) begin
            errors++;
            $display("FAIL %s: byp_vld=%0b tag=%0d expected byp_vld=%0b tag=%0d",
                     req, byp_vld, byp_tag, v, t);
        end
    endtask

    task automatic set_op(logic [1:0] k, logic [1:0] sz, logic [REG_W-1:0] b,
                          logic [DISP_W-1:0] d, logic [TAG_W-1:0] t);
        op_vld = 1; op_kind = k; op_size = sz; op_gpr = 1; op_base_vld = 1;
        op_base = b; op_idx_vld = 0; op_idx = '0; op_scale = 2'd1; op_disp = d; op_ptag = t;
    endtask

    task automatic clear_table();
        vfy_vld = 1; vfy_pred_hit = 1; vfy_alias = 0; vfy_ltag = 7'd99;
        tick("R10 flush");
    endtask

    initial begin
        idle();
        model_clear();
        rst = 1;
        repeat (3) @(negedge clk);
        checks++;
        if (byp_vld !== 1'b0 || flush_req !== 1'b0) begin
            errors++;
            $display("FAIL R3 reset: byp=%0b flush=%0b expected 0 0", byp_vld, flush_req);
        end
        rst = 0;

        // R4 chain store -> rmw -> load
        set_op(2'd1, 2'd2, 4'd3, 32'd16, 7'd10); tick("R4 store");
        set_op(2'd2, 2'd2, 4'd3, 32'd16, 7'd11); tick("R4 rmw");
        expect_byp("R4 rmw bypass", 1, 7'd10);
        set_op(2'd0, 2'd2, 4'd3, 32'd16, 7'd0);  tick("R4 load");
        expect_byp("R4 load bypass", 1, 7'd11);
        // R3 size must match exactly
        set_op(2'd0, 2'd3, 4'd3, 32'd16, 7'd0);  tick("R3 size");
        expect_byp("R3 size mismatch", 0, 7'd0);

        // R1 narrow or non-gpr operands
        clear_table();
        set_op(2'd1, 2'd0, 4'd2, 32'd0, 7'd12); tick("R1 store8");
        set_op(2'd0, 2'd0, 4'd2, 32'd0, 7'd0);  tick("R1 load8");
        expect_byp("R1 8-bit", 0, 7'd0);
        set_op(2'd1, 2'd2, 4'd2, 32'd4, 7'd13); op_gpr = 0; tick("R1 store vec");
        set_op(2'd0, 2'd2, 4'd2, 32'd4, 7'd0);  tick("R1 load gpr");
        expect_byp("R1 non-gpr producer", 0, 7'd0);

        // R2 absolute address
        set_op(2'd1, 2'd2, 4'd0, 32'd64, 7'd14); op_base_vld = 0; tick("R2 store");
        set_op(2'd0, 2'd2, 4'd0, 32'd64, 7'd0);  op_base_vld = 0; tick("R2 load");
        expect_byp("R2 no base", 0, 7'd0);

        // R6 push then pop
        clear_table();
        set_op(2'd1, 2'd2, SP_ID, 32'd0, 7'd20); tick("R6 store");
        sp_vld = 1; sp_delta = 32'hFFFF_FFF8;
        set_op(2'd0, 2'd2, SP_ID, 32'd8, 7'd0); tick("R6 push load");
        expect_byp("R6 after push", 1, 7'd20);
        sp_vld = 1; sp_delta = 32'd8;
        set_op(2'd0, 2'd2, SP_ID, 32'd0, 7'd0); tick("R6 pop load");
        expect_byp("R6 after pop", 1, 7'd20);
        // R8 frame pointer copy never matches
        set_op(2'd0, 2'd2, 4'd5, 32'd0, 7'd0); tick("R8 fp load");
        expect_byp("R8 copy of sp", 0, 7'd0);
        // R7 explicit stack pointer write
        rw_vld = 1; rw_reg = SP_ID; tick("R7 sp write");
        set_op(2'd0, 2'd2, SP_ID, 32'd0, 7'd0); tick("R7 load");
        expect_byp("R7 sp write invalidates", 0, 7'd0);
        set_op(2'd1, 2'd3, 4'd6, 32'd0, 7'd21); op_idx_vld = 1; op_idx = 4'd7; tick("R7 store");
        rw_vld = 1; rw_reg = 4'd7; tick("R7 idx write");
        set_op(2'd0, 2'd3, 4'd6, 32'd0, 7'd0); op_idx_vld = 1; op_idx = 4'd7; tick("R7 load");
        expect_byp("R7 index write invalidates", 0, 7'd0);

        // R5 youngest wins
        clear_table();
        set_op(2'd1, 2'd2, 4'd2, 32'd4, 7'd30); tick("R5 store a");
        set_op(2'd1, 2'd2, 4'd2, 32'd4, 7'd31); tick("R5 store b");
        set_op(2'd0, 2'd2, 4'd2, 32'd4, 7'd0);  tick("R5 load");
        expect_byp("R5 youngest", 1, 7'd31);

        // R9 round-robin wrap
        clear_table();
        for (int n = 0; n < 9; n++) begin
            set_op(2'd1, 2'd2, 4'd3, 32'(n * 4), 7'(40 + n)); tick("R9 fill");
        end
        set_op(2'd0, 2'd2, 4'd3, 32'd0, 7'd0); tick("R9 evicted");
        expect_byp("R9 oldest overwritten", 0, 7'd0);
        set_op(2'd0, 2'd2, 4'd3, 32'd4, 7'd0); tick("R9 kept");
        expect_byp("R9 second kept", 1, 7'd41);

        // R10 mispredict flush and agreement
        set_op(2'd1, 2'd2, 4'd1, 32'd0, 7'd50); tick("R10 store");
        vfy_vld = 1; vfy_pred_hit = 0; vfy_alias = 1; vfy_ltag = 7'd77; tick("R10 mismatch");
        checks++;
        if (flush_req !== 1'b1 || flush_tag !== 7'd77) begin
            errors++;
            $display("FAIL R10: flush=%0b tag=%0d expected 1 77", flush_req, flush_tag);
        end
        set_op(2'd0, 2'd2, 4'd1, 32'd0, 7'd0); tick("R10 load");
        expect_byp("R10 table cleared", 0, 7'd0);
        vfy_vld = 1; vfy_pred_hit = 1; vfy_alias = 1; tick("R10 agree");
        checks++;
        if (flush_req !== 1'b0) begin
            errors++;
            $display("FAIL R10: flush=%0b expected 0", flush_req);
        end

        // R11 same-cycle ordering
        clear_table();
        set_op(2'd1, 2'd2, 4'd7, 32'd0, 7'd60); rw_vld = 1; rw_reg = 4'd7; tick("R11 store+write");
        set_op(2'd0, 2'd2, 4'd7, 32'd0, 7'd0); tick("R11 load");
        expect_byp("R11 event before op", 1, 7'd60);
        set_op(2'd1, 2'd2, 4'd2, 32'd0, 7'd61);
        vfy_vld = 1; vfy_pred_hit = 1; vfy_alias = 0; tick("R11 store+flush");
        set_op(2'd0, 2'd2, 4'd2, 32'd0, 7'd0); tick("R11 load");
        expect_byp("R11 flush cancels alloc", 0, 7'd0);

        // random phase
        void'($urandom(32'd20240611));
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = $urandom;
            op_vld = r[0] | r[1];
            op_kind = r[3:2];
            op_size = r[4] ? 2'd2 : (r[5] ? 2'd3 : r[7:6]);
            op_gpr = (r[10:8] != 3'd0);
            op_base_vld = (r[13:11] != 3'd0);
            case (r[15:14])
                2'd0: op_base = 4'd2;
                2'd1: op_base = 4'd3;
                2'd2: op_base = SP_ID;
                default: op_base = 4'd5;
            endcase
            op_idx_vld = (r[17:16] == 2'd0);
            op_idx = r[18] ? 4'd1 : SP_ID;
            op_scale = {1'b0, r[19]};
            case (r[21:20])
                2'd0: op_disp = 32'd0;
                2'd1: op_disp = 32'd8;
                2'd2: op_disp = 32'd16;
                default: op_disp = 32'hFFFF_FFF8;
            endcase
            op_ptag = 7'($urandom);
            rw_vld = (r[25:22] == 4'd0);
            rw_reg = {1'b0, r[28:26]};
            r = $urandom;
            sp_vld = (r[2:0] == 3'd0);
            sp_delta = r[3] ? 32'd8 : 32'hFFFF_FFF8;
            vfy_vld = (r[7:4] == 4'd0);
            vfy_pred_hit = r[8];
            vfy_alias = r[9];
            vfy_ltag = 7'(r[16:10]);
            tick("R3 R6 R7 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule